// File: doc/BRIEF.md
# SPI Read Sample-Delay Calibration Sequencer

This engine finds a reliable read-data sample delay for each serial-clock divider of a flash read path. On a start pulse it reads a reference block once through the flash path at the safe, slow setting and keeps it in a local buffer. While doing so it counts the words that are neither all zeros nor all ones. If too few such words exist, the block cannot tell good timing from bad, so the engine gives up, reports an error and leaves the timing register alone.

When the reference is usable, the engine walks the dividers from 5 downwards. It stops at a programmable floor, which stands for the fastest divider that still meets the maximum clock rate. For each divider it steps through twelve candidate delay codes in order and places each code into that divider's nibble of the timing register. It then rereads the whole block several times and compares every word with the buffered copy.

Three passing codes in a row end the sweep for that divider, and the middle code of the three is programmed. The smallest divider that calibrates is reported together with a one-cycle done pulse.

Top module: `spi_rdcal_top`

## Requirements
- R1: After reset, done, err and rd_req are 0, sel_div is 0 and timing_reg is all zeros.
- R2: After start, the engine issues exactly WORDS reference reads with rd_gold=1, at addresses 0, 1, … WORDS-1 in that order. Each request is a single-cycle rd_req pulse and is answered by one rd_vld cycle.
- R3: A word counts as varied when it is neither 0 nor all ones. If fewer than MIN_VARIED reference words are varied, the engine raises done with err=1 and sel_div=0, issues no sweep reads and leaves timing_reg unchanged. Exactly MIN_VARIED varied words is enough to proceed.
- R4: While candidate i (0..11) is under test for divider d, nibble bits [4(d-1)+3 : 4(d-1)] of timing_reg hold code {bit3 = 1 when i is even, bits 2:0 = i/2}. All other nibbles keep their values.
- R5: Each candidate rereads the full block REPEATS times with rd_gold=0 and rd_div=d. The first word that differs from the reference fails the candidate, and its remaining reads are skipped.
- R6: The count of consecutive passing candidates restarts at zero on a failure. When it reaches 3 at candidate i, the sweep of that divider stops and the nibble is set to the code of candidate i-1.
- R7: If a divider sees no run of three passes, it is rejected and its nibble is left at the last candidate's code (0x5).
- R8: Dividers are tried in the order 5, 4, … down to the floor input (a floor of 0 acts as 1). Dividers below the floor get no reads and keep their nibbles.
- R9: At the end, done is high for exactly one cycle. sel_div is the smallest divider that calibrated, or 0 if none did, and err is 1 exactly when sel_div is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a calibration run (accepted while idle) |
| div_floor | input | 3 | Smallest divider allowed to be tried |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Run failed: uniform reference or no divider passed |
| sel_div | output | 3 | Smallest calibrated divider, 0 if none |
| timing_reg | output | 20 | Five 4-bit delay codes, divider d at nibble d-1 |
| rd_req | output | 1 | One-cycle read request to the flash path |
| rd_addr | output | AW | Word index of the request |
| rd_gold | output | 1 | 1: use the safe slow read setting |
| rd_div | output | 3 | Divider under test (sweep reads) |
| rd_vld | input | 1 | Read data valid |
| rd_data | input | 32 | Read data word |

## Verification
A flash model serves a reference block with a chosen number of varied words. For each divider it applies a pass/fail mask over the twelve codes and decodes the code under test from the timing register. Masks with a clean run at the start, in the middle and at the end of the sweep, with runs broken after two passes, and with no passes at all show whether the middle code is chosen, whether the run count restarts and how a rejected divider is left. Two varied-word counts, one just below and one at the threshold, separate rejection from acceptance. Floors of 1, 3, 5 and 7, together with a run where every code passes, show the divider order, the choice of the smallest divider and that lower nibbles are preserved. Counting reference and sweep reads shows the repeat count and the early exit on a mismatch.

// File: rtl/spi_rdcal_pkg.sv
package spi_rdcal_pkg;
  localparam int NDIV  = 5;
  localparam int NCAND = 12;
  localparam int TW    = NDIV * 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_GREQ, ST_GWAIT, ST_QUAL, ST_DSEL,
    ST_CSET, ST_SREQ, ST_SWAIT, ST_CEND, ST_DNEXT
  } cal_state_t;

  function automatic logic [3:0] cand_code(input logic [3:0] idx);
    return {~idx[0], idx[3:1]};
  endfunction

  function automatic logic [TW-1:0] put_nib(input logic [TW-1:0] r,
                                            input logic [2:0] d,
                                            input logic [3:0] c);
    logic [TW-1:0] o;
    o = r;
    for (int k = 0; k < NDIV; k++)
      if (d == 3'(k + 1)) o[k*4 +: 4] = c;
    return o;
  endfunction
endpackage

// File: rtl/spi_rdcal_ram.sv
module spi_rdcal_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_rdcal_qual.sv
module spi_rdcal_qual #(
  parameter int WORDS      = 256,
  parameter int DW         = 32,
  parameter int MIN_VARIED = 64,
  localparam int CW        = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          vld,
  input  logic [DW-1:0] data,
  output logic          enough
);
  logic [CW-1:0] cnt;
  logic          varied;

  assign varied = (data != '0) && (data != '1);
  assign enough = (cnt >= CW'(MIN_VARIED));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (vld && varied && cnt != CW'(WORDS)) cnt <= cnt + 1'b1;
  end

  AST_QUAL_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(WORDS)); // R3
endmodule

// File: rtl/spi_rdcal_run.sv
module spi_rdcal_run #(
  parameter int RUN_LEN = 3,
  localparam int RW     = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic pass,
  output logic hit
);
  logic [RW-1:0] run;

  assign hit = step && pass && (run == RW'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) run <= '0;
    else if (step) begin
      if (!pass || hit) run <= '0;
      else run <= run + 1'b1;
    end
  end

  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    run < RW'(RUN_LEN)); // R6
  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
    (step && !pass) |=> (run == '0)); // R6
endmodule

// File: rtl/spi_rdcal_top.sv
module spi_rdcal_top
  import spi_rdcal_pkg::*;
#(
  parameter int WORDS      = 256,
  parameter int MIN_VARIED = 64,
  parameter int REPEATS    = 10,
  parameter int RUN_LEN    = 3,
  localparam int DW        = 32,
  localparam int AW        = $clog2(WORDS),
  localparam int PW        = $clog2(REPEATS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    div_floor,
  output logic          done,
  output logic          err,
  output logic [2:0]    sel_div,
  output logic [TW-1:0] timing_reg,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          rd_gold,
  output logic [2:0]    rd_div,
  input  logic          rd_vld,
  input  logic [DW-1:0] rd_data
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);
  localparam logic [3:0]    BACK = 4'(RUN_LEN / 2);

  cal_state_t    st;
  logic [AW-1:0] addr;
  logic [2:0]    dv;
  logic [2:0]    floor_q;
  logic [3:0]    cand;
  logic [PW-1:0] rep;
  logic          cand_pass;
  logic [DW-1:0] gold_q;
  logic          enough;
  logic          hit;
  logic          gwr;

  assign gwr     = (st == ST_GWAIT) && rd_vld;
  assign rd_addr = addr;
  assign rd_div  = dv;
  assign rd_gold = (st == ST_GREQ) || (st == ST_GWAIT);

  spi_rdcal_ram #(.DEPTH(WORDS), .DW(DW)) i_ram (
    .clk(clk), .we(gwr), .waddr(addr), .wdata(rd_data),
    .raddr(addr), .rdata(gold_q)
  );

  spi_rdcal_qual #(.WORDS(WORDS), .DW(DW), .MIN_VARIED(MIN_VARIED)) i_qual (
    .clk(clk), .rst(rst), .clr(st == ST_IDLE), .vld(gwr),
    .data(rd_data), .enough(enough)
  );

  spi_rdcal_run #(.RUN_LEN(RUN_LEN)) i_run (
    .clk(clk), .rst(rst), .clr(st == ST_DSEL), .step(st == ST_CEND),
    .pass(cand_pass), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      done       <= 1'b0;
      err        <= 1'b0;
      sel_div    <= '0;
      timing_reg <= '0;
      rd_req     <= 1'b0;
      addr       <= '0;
      dv         <= '0;
      floor_q    <= 3'd1;
      cand       <= '0;
      rep        <= '0;
      cand_pass  <= 1'b0;
    end else begin
      done   <= 1'b0;
      rd_req <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          addr    <= '0;
          err     <= 1'b0;
          sel_div <= '0;
          floor_q <= (div_floor == 3'd0) ? 3'd1 : div_floor;
          st      <= ST_GREQ;
        end
        ST_GREQ: begin
          rd_req <= 1'b1;
          st     <= ST_GWAIT;
        end
        ST_GWAIT: if (rd_vld) begin
          if (addr == LAST) st <= ST_QUAL;
          else begin
            addr <= addr + 1'b1;
            st   <= ST_GREQ;
          end
        end
        ST_QUAL: begin
          addr <= '0;
          if (!enough) begin
            done <= 1'b1;
            err  <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            dv <= 3'(NDIV);
            st <= ST_DSEL;
          end
        end
        ST_DSEL: begin
          if (dv < floor_q) begin
            done <= 1'b1;
            err  <= (sel_div == 3'd0);
            st   <= ST_IDLE;
          end else begin
            cand <= '0;
            st   <= ST_CSET;
          end
        end
        ST_CSET: begin
          timing_reg <= put_nib(timing_reg, dv, cand_code(cand));
          rep        <= '0;
          addr       <= '0;
          st         <= ST_SREQ;
        end
        ST_SREQ: begin
          rd_req <= 1'b1;
          st     <= ST_SWAIT;
        end
        ST_SWAIT: if (rd_vld) begin
          if (rd_data != gold_q) begin
            cand_pass <= 1'b0;
            st        <= ST_CEND;
          end else if (addr == LAST) begin
            addr <= '0;
            if (rep == PW'(REPEATS - 1)) begin
              cand_pass <= 1'b1;
              st        <= ST_CEND;
            end else begin
              rep <= rep + 1'b1;
              st  <= ST_SREQ;
            end
          end else begin
            addr <= addr + 1'b1;
            st   <= ST_SREQ;
          end
        end
        ST_CEND: begin
          if (hit) begin
            timing_reg <= put_nib(timing_reg, dv, cand_code(cand - BACK));
            sel_div    <= dv;
            st         <= ST_DNEXT;
          end else if (cand == 4'(NCAND - 1)) begin
            st <= ST_DNEXT;
          end else begin
            cand <= cand + 1'b1;
            st   <= ST_CSET;
          end
        end
        ST_DNEXT: begin
          dv <= dv - 1'b1;
          st <= ST_DSEL;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_ERR_NO_DIV: assert property (@(posedge clk) disable iff (rst)
    (done && sel_div == 3'd0) |-> err); // R9
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req); // R2
  AST_TREG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st != ST_CSET && st != ST_CEND) |=> $stable(timing_reg)); // R4
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (sel_div <= 3'(NDIV))); // R8
  AST_SWEEP_DIV: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_gold) |-> (rd_div >= 3'd1 && rd_div <= 3'(NDIV))); // R5
endmodule

// File: tb/test_spi_rdcal_top.sv
module test_spi_rdcal_top;
  localparam int W   = 16;
  localparam int MV  = 4;
  localparam int REP = 2;
  localparam int AW  = $clog2(W);

  typedef struct {
    logic [2:0]  sel;
    logic        err;
    logic [19:0] treg;
    int          gold_n;
    int          sweep_n;
  } exp_t;

  logic clk = 0, rst = 1, start = 0;
  logic [2:0] div_floor = 0;
  logic done, err, rd_req, rd_gold, rd_vld = 0;
  logic [2:0] sel_div, rd_div;
  logic [19:0] timing_reg;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data = 0;

  int checks = 0, fails = 0;
  int gold_n = 0, sweep_n = 0, gold_order_bad = 0;
  int kvar = W;
  logic [11:0] pm [0:7];
  logic [19:0] exp_treg = 0;
  exp_t q[$];
  bit finished = 0;

  always #2 clk = ~clk;

  spi_rdcal_top #(.WORDS(W), .MIN_VARIED(MV), .REPEATS(REP)) i_spi_rdcal_top (
    .clk(clk), .rst(rst), .start(start), .div_floor(div_floor),
    .done(done), .err(err), .sel_div(sel_div), .timing_reg(timing_reg),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_gold(rd_gold), .rd_div(rd_div),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    if (a < kvar) return 32'hA5C3_0000 + 32'(a);
    return (a % 2 == 0) ? 32'h0 : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [3:0] code(input int i);
    return {(i % 2 == 0), 3'(i / 2)};
  endfunction

  // flash path model
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        logic [31:0] dat;
        int a;
        a = int'(rd_addr);
        dat = pat(a);
        if (rd_gold) begin
          if (a != gold_n) gold_order_bad++;
          gold_n++;
        end else begin
          logic [3:0] c;
          int ci;
          c = timing_reg[(int'(rd_div) - 1) * 4 +: 4];
          ci = int'(c[2:0]) * 2 + (c[3] ? 0 : 1);
          sweep_n++;
          if (!pm[rd_div][ci] && a == W - 1) dat = dat ^ 32'h1;
        end
        @(negedge clk);
        rd_vld = 1;
        rd_data = dat;
        @(negedge clk);
        rd_vld = 0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        exp_t e;
        if (q.size() == 0) begin
          chk("R9 unexpected done", 1, 0);
        end else begin
          e = q.pop_front();
          chk("R9 sel_div", 32'(sel_div), 32'(e.sel));
          chk("R9 err", 32'(err), 32'(e.err));
          chk("R4 R6 R7 R8 timing_reg", 32'(timing_reg), 32'(e.treg));
          chk("R2 reference reads", gold_n, e.gold_n);
          chk("R2 reference address order", gold_order_bad, 0);
          chk("R3 R5 sweep reads", sweep_n, e.sweep_n);
        end
        @(negedge clk);
        chk("R9 done one cycle", 32'(done), 0);
      end
    end
  end

  task automatic launch(input logic [2:0] fl, input int k,
                        input logic [11:0] m5, input logic [11:0] m4,
                        input logic [11:0] m3, input logic [11:0] m2,
                        input logic [11:0] m1);
    exp_t e;
    int lo;
    pm[5] = m5; pm[4] = m4; pm[3] = m3; pm[2] = m2; pm[1] = m1;
    kvar = k;
    e.gold_n = W;
    e.sweep_n = 0;
    e.sel = 0;
    if (k < MV) begin
      e.err = 1;
    end else begin
      lo = (fl == 0) ? 1 : int'(fl);
      for (int d = 5; d >= lo; d--) begin
        int run;
        bit found;
        run = 0;
        found = 0;
        for (int i = 0; i < 12 && !found; i++) begin
          if (pm[d][i]) begin
            run++;
            e.sweep_n += W * REP;
            if (run == 3) begin
              found = 1;
              exp_treg[(d-1)*4 +: 4] = code(i - 1);
              e.sel = 3'(d);
            end
          end else begin
            run = 0;
            e.sweep_n += W;
          end
        end
        if (!found) exp_treg[(d-1)*4 +: 4] = code(11);
      end
      e.err = (e.sel == 0);
    end
    e.treg = exp_treg;
    q.push_back(e);
    gold_n = 0;
    sweep_n = 0;
    gold_order_bad = 0;
    @(negedge clk);
    div_floor = fl;
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) pm[i] = '1;
    repeat (3) @(negedge clk);
    chk("R1 done", 32'(done), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 sel_div", 32'(sel_div), 0);
    chk("R1 timing_reg", 32'(timing_reg), 0);
    chk("R1 rd_req", 32'(rd_req), 0);
    rst = 0;
    @(negedge clk);
    // R6 mid-sweep run, R7 no pass, R6 run broken after two passes, R7 pairs only
    launch(3'd1, W, 12'b0000_0011_1000, 12'b0, 12'b0000_0111_0110,
           12'b1100_0000_0011, 12'b0111_0000_0000);
    chk("R8 run A result 0xA5254", 32'(timing_reg), 32'hA5254);
    // R8 floor 3: lower nibbles keep the values from run A
    launch(3'd3, W, 12'b1110_0000_0000, 12'b0000_0000_0111, 12'b0,
           12'b0, 12'b0);
    // R3 one varied word short of the threshold
    launch(3'd1, MV - 1, '1, '1, '1, '1, '1);
    // R3 exactly at the threshold
    launch(3'd5, MV, 12'b0000_0000_0111, '1, '1, '1, '1);
    // R8 floor above every divider
    launch(3'd7, W, '1, '1, '1, '1, '1);
    // R9 all pass, smallest divider wins, floor 0 acts as 1
    launch(3'd0, W, '1, '1, '1, '1, '1);
    chk("R9 final sel_div", 32'(sel_div), 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule